// File: doc/BRIEF.md
# Reset and Interrupt Control Register

This block is a small memory-mapped control register inside a data-acquisition DMA controller. Software writes it to release five groups of downstream devices from reset, one active-low reset line per group: front-end devices, input FIFOs, latch devices, address generators and output FIFOs. Each group stays in reset while its control bit is 0.

The same register folds four completion sources into one host interrupt request. Each source pulses a done input for one cycle. The block latches that pulse into a sticky done flag, which stays set until software clears it. A source contributes to the interrupt when both its enable bit and its done flag are set. A software force bit can also raise the request, for debug. No request leaves the block unless the master interrupt enable is set. Software reads back every control field, the done flags and the raw interrupt condition before the master gate. It uses that raw condition to see which condition is pending.

The host port is a simple synchronous port. A write takes effect at the clock edge where `wr_en` is high. `rd_data` shows the register chosen by `addr` combinationally. Address 0 is the control word. Address 1 is the done/status word and is also where write-one-to-clear takes place.

Top module: `rst_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, all five `grp_rst_n` lines are 0, `host_irq` is 0, and both readable words read as 0.
- R2: A write to address 0 loads bits 4:0 into the reset-control bits. Bit i drives `grp_rst_n[i]` from the next clock edge: 1 releases the group and 0 holds it in reset. The group order is front-end devices, input FIFOs, latch devices, address generators, output FIFOs.
- R3: A one-cycle high on `done_pulse[k]` sets done flag k. The flag then stays at 1 through any number of cycles until it is cleared.
- R4: A write to address 1 clears done flag k where data bit k is 1, and leaves flags with a 0 data bit unchanged. A set pulse in the same cycle as a clear of the same flag wins, and the flag stays 1.
- R5: `host_irq` is 1 one clock after a cycle in which the master enable is 1 and either some source has both enable and done set, or the force bit is 1. Otherwise it is 0 one clock later.
- R6: While the master enable (address 0, bit 16) is 0, `host_irq` stays 0 whatever the done flags, enables and force bit (address 0, bit 17) hold.
- R7: Reading address 0 returns the reset bits in 4:0, the source enables in 11:8, the master enable in 16 and force in 17, with all other bits 0. Reading address 1 returns the done flags in 3:0 and the raw ungated interrupt condition in bit 8, with all other bits 0.
- R8: An active source interrupt goes away one clock after either its enable bit or its done flag is cleared. A forced interrupt goes away only when force is written back to 0.
- R9: Writes to addresses 2 and 3 change no state, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| wr_en | input | 1 | Write strobe, taken at the clock edge |
| addr | input | 2 | Register address for both read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| done_pulse | input | 4 | One-cycle completion pulses from the four sources |
| grp_rst_n | output | 5 | Active-low resets for the five device groups |
| host_irq | output | 1 | Registered host interrupt request |

## Verification
The bench aims at the cases where the set and clear paths meet. A done pulse arrives in the same cycle as its own write-one-to-clear. A design that gave the clear priority would lose a completion, and the done flag would read 0. The bench also checks the master gate against both a pending source and the force bit. A design that routed force around the gate would interrupt the host while the master enable is 0. The interrupt output is checked one clock after each cause appears and after each of the two ways to remove it, so an unregistered output or a one-cycle-late output shows up as a mismatch. Writes to the unused addresses are checked to leave every field unchanged. A mis-decoded address would corrupt the reset lines or the enables.

// File: rtl/rst_irq_ctrl.sv
module rst_irq_ctrl #(
  parameter int N_RST = 5,
  parameter int N_SRC = 4,
  parameter int DW    = 32,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  input  logic [N_SRC-1:0] done_pulse,
  output logic [N_RST-1:0] grp_rst_n,
  output logic             host_irq
);
  localparam int EN_LSB  = 8;
  localparam int MEN_BIT = 16;
  localparam int FRC_BIT = 17;
  localparam int RAW_BIT = 8;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_DONE = AW'(1);

  logic [N_RST-1:0] rst_q;
  logic [N_SRC-1:0] en_q, done_q, clr_mask;
  logic             men_q, frc_q, raw;

  wire wr_ctrl = wr_en && (addr == A_CTRL);
  wire wr_done = wr_en && (addr == A_DONE);

  assign clr_mask  = wr_done ? wr_data[N_SRC-1:0] : '0;
  assign raw       = (|(done_q & en_q)) | frc_q;
  assign grp_rst_n = rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= '0;
      en_q  <= '0;
      men_q <= 1'b0;
      frc_q <= 1'b0;
    end else if (wr_ctrl) begin
      rst_q <= wr_data[N_RST-1:0];
      en_q  <= wr_data[EN_LSB +: N_SRC];
      men_q <= wr_data[MEN_BIT];
      frc_q <= wr_data[FRC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= '0;
    else        done_q <= (done_q & ~clr_mask) | done_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_irq <= 1'b0;
    else        host_irq <= men_q & raw;
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTRL: begin
        rd_data[N_RST-1:0]         = rst_q;
        rd_data[EN_LSB +: N_SRC]   = en_q;
        rd_data[MEN_BIT]           = men_q;
        rd_data[FRC_BIT]           = frc_q;
      end
      A_DONE: begin
        rd_data[N_SRC-1:0] = done_q;
        rd_data[RAW_BIT]   = raw;
      end
      default: rd_data = '0;
    endcase
  end

  logic [N_SRC-1:0] keep;
  assign keep = done_q & ~clr_mask;

  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> $past(men_q));

  p_force_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (men_q && frc_q) |=> host_irq);

  p_done_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((done_q & $past(keep)) == $past(keep)));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_pulse) |=> ((done_q & $past(done_pulse)) == $past(done_pulse)));

  p_rst_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (grp_rst_n == $past(wr_data[N_RST-1:0])));

  p_idle_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!frc_q && ((done_q & en_q) == '0)) |=> !host_irq);

endmodule

// File: tb/rst_irq_ctrl_bench.sv
module rst_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  done_pulse = '0;
  logic [4:0]  grp_rst_n;
  logic        host_irq;

  rst_irq_ctrl u_rst_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .done_pulse(done_pulse), .grp_rst_n(grp_rst_n),
    .host_irq(host_irq)
  );

  always #10 clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  string tag = "R1";
  bit    finished = 0;

  logic [4:0] m_rst = '0;
  logic [3:0] m_en = '0, m_done = '0;
  bit         m_men = 0, m_frc = 0, m_irq = 0;

  function automatic bit m_raw();
    return ((m_done & m_en) != 0) || m_frc;
  endfunction

  function automatic logic [31:0] m_read(input logic [1:0] a);
    logic [31:0] r = '0;
    if (a == 2'd0) begin
      r[4:0] = m_rst; r[11:8] = m_en; r[16] = m_men; r[17] = m_frc;
    end else if (a == 2'd1) begin
      r[3:0] = m_done; r[8] = m_raw();
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rst = '0; m_en = '0; m_done = '0; m_men = 0; m_frc = 0; m_irq = 0;
    end else begin
      m_irq = m_men && m_raw();
      if (wr_en && addr == 2'd1) m_done = m_done & ~wr_data[3:0];
      m_done = m_done | done_pulse;
      if (wr_en && addr == 2'd0) begin
        m_rst = wr_data[4:0]; m_en = wr_data[11:8];
        m_men = wr_data[16]; m_frc = wr_data[17];
      end
    end
  end

  always @(negedge clk) if (!finished) begin
    checks++;
    if (grp_rst_n !== m_rst) begin
      errors++; $display("FAIL %s grp_rst_n actual=%h expected=%h", tag, grp_rst_n, m_rst);
    end
    checks++;
    if (host_irq !== m_irq) begin
      errors++; $display("FAIL %s host_irq actual=%b expected=%b", tag, host_irq, m_irq);
    end
    checks++;
    if (rd_data !== m_read(addr)) begin
      errors++; $display("FAIL %s rd_data@%0d actual=%h expected=%h", tag, addr, rd_data, m_read(addr));
    end
  end

  task automatic cyc(input bit w, input logic [1:0] a, input logic [31:0] d, input logic [3:0] p);
    @(negedge clk); #1;
    wr_en = w; addr = a; wr_data = d; done_pulse = p;
  endtask

  task automatic idle(input logic [1:0] a, input int n);
    for (int i = 0; i < n; i++) cyc(0, a, '0, '0);
  endtask

  initial begin
    tag = "R1"; idle(2'd0, 3); idle(2'd1, 2);
    @(negedge clk); #1 rst_n = 1'b1;
    idle(2'd0, 2); idle(2'd1, 2);

    tag = "R2";
    cyc(1, 0, 32'h0000_0015, 0); idle(0, 2);
    cyc(1, 0, 32'h0000_001F, 0); idle(0, 1);
    cyc(1, 0, 32'h0000_000A, 0); idle(0, 1);
    tag = "R7"; cyc(1, 0, 32'h0003_0F13, 0); cyc(1, 0, 32'h0000_0013, 0); idle(0, 1);

    tag = "R3"; cyc(0, 1, 0, 4'b0010); idle(1, 5);
    tag = "R6"; cyc(1, 0, 32'h0000_0213, 0); idle(1, 3);
    cyc(1, 0, 32'h0002_0F13, 0); idle(1, 3);
    tag = "R5"; cyc(1, 0, 32'h0001_0213, 0); idle(1, 3);
    tag = "R8"; cyc(1, 0, 32'h0001_0013, 0); idle(1, 2);
    cyc(1, 0, 32'h0001_0213, 0); idle(1, 2);
    tag = "R4"; cyc(1, 1, 32'h0000_0001, 0); idle(1, 2);
    cyc(1, 1, 32'h0000_0002, 0); idle(1, 2);
    cyc(0, 1, 0, 4'b0100); cyc(1, 1, 32'h0000_0004, 4'b0100); idle(1, 2);
    cyc(1, 1, 32'h0000_000F, 4'b1000); idle(1, 2);
    tag = "R8"; cyc(1, 0, 32'h0003_0013, 0); idle(1, 3);
    cyc(1, 0, 32'h0001_0013, 0); idle(1, 2);

    tag = "R9";
    cyc(1, 0, 32'h0001_0F1F, 4'b0011); idle(1, 1);
    cyc(1, 2, 32'hFFFF_FFF0, 0); idle(0, 1); idle(2, 1);
    cyc(1, 3, 32'h0000_0000, 0); idle(1, 1); idle(3, 1); idle(0, 1);

    tag = "R5";
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d = $urandom;
      logic [3:0]  p = ($urandom % 4 == 0) ? 4'($urandom) : 4'b0;
      cyc(($urandom % 3) == 0, 2'($urandom), d, p);
    end
    idle(1, 2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule